// File: doc/BRIEF.md
# Cascadable Dual 8-bit Timer with Carrier and Baud Tick

Two up-counters, a low and a high unit, each with its own compare register and its own count-event source. The source is the core clock, one of two prescaled clock enables, or the rising edges of a dedicated external count pin. A count that reaches the compare value clears to zero and fires a single-cycle interrupt pulse. Each unit drives an output pin with either a square wave that flips on every match or a PWM waveform set by the compare value.

Software sets a chain bit to join the two units into one 16-bit counter, with the high unit holding the upper byte. The overflow event of the high unit feeds two outputs. One is a carrier with 1/2 or 1/3 duty for infrared remote control. The other is a tick at half the overflow rate, for a serial baud generator. Software programs the block through a simple write bus and stops a unit before changing its settings.

Top module: `tmr_pair`

## Requirements
- R1: With an enabled unit clocked every cycle, the counter counts 0 up to the compare value C and then clears, so matches repeat every C+1 cycles. Each match gives a one-cycle interrupt pulse, seen C+1 cycles after the clock edge that writes the enable. C=0 gives a pulse on every cycle.
- R2: The mode field source[2:1] selects the count events: 0 counts every cycle, 1 counts on `ce_div4`, 2 counts on `ce_div16`, 3 counts on rising edges of that unit's `ext_cnt` bit after a two-flop synchronizer. A pin held high for many cycles counts once.
- R3: With mode bit 3 clear, the unit's pin flips on every match, so its period is 2*(C+1) counts.
- R4: With mode bit 3 set, the unit's pin is a PWM output that is high while the count is below C. C=0x00 keeps it low. C=0xFF keeps it high for 255 of every 256 counts.
- R5: With the chain bit (bit 4 of the high mode) set, {high,low} form one 16-bit counter. It is clocked by the low unit's source and enable, and the high unit's own source and enable are ignored. Only a match of both bytes clears the counter, and that match pulses `irq_hi` every {Chi,Clo}+1 counts while `irq_lo` stays low.
- R6: With mode bit 0 (run) clear, a unit's counter is held at zero, its pin is low and it raises no interrupt.
- R7: With the route bit (bit 5 of the high mode) set, `pin_hi` carries the low unit's PWM waveform.
- R8: When the carrier is enabled (carrier register bit 0), `carrier_out` is high for one of every two overflow intervals of the high unit, or one of every three when bit 1 is set. When the carrier is disabled, `carrier_out` is low.
- R9: `baud_tick` is a one-cycle pulse on every second overflow of the high unit.
- R10: After reset all outputs are low and both units are stopped.
- R11: Write addresses are 0 for the low mode, 1 for the low compare, 2 for the high mode, 3 for the high compare and 4 for the carrier control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | W | Write data |
| ce_div4 | input | 1 | Prescaled count enable, clock/4 |
| ce_div16 | input | 1 | Prescaled count enable, clock/16 |
| ext_cnt | input | 2 | External count pins, bit 0 for the low unit, bit 1 for the high unit |
| irq_lo | output | 1 | Low unit match pulse |
| irq_hi | output | 1 | High unit or 16-bit match pulse |
| pin_lo | output | 1 | Low unit square-wave or PWM pin |
| pin_hi | output | 1 | High unit square-wave, PWM or routed PWM pin |
| carrier_out | output | 1 | Remote-control carrier |
| baud_tick | output | 1 | Half-overflow-rate tick |

## Verification
With the clock source, an interrupt pulse appears one cycle after the edge whose count equals the compare value. The first pulse therefore shows C+1 cycles after the enable write, and later pulses are spaced C+1 cycles apart, or that many prescaler strobes. The bench counts rising edges from the write edge and samples on the falling edge. External pin counts arrive three edges after the pin rises, so the pulse widths in the bench leave room for that delay before each count is judged. PWM, toggle and carrier outputs have one register stage, so they are measured as high-time or transition totals over windows that span whole periods, after a warm-up.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_CORE  = 2'd0,
    SRC_DIV4  = 2'd1,
    SRC_DIV16 = 2'd2,
    SRC_PIN   = 2'd3
  } src_e;

  // field order fixes the bit positions software writes
  typedef struct packed {
    logic route;  // bit 5
    logic chain;  // bit 4
    logic pwm;    // bit 3
    src_e src;    // bits 2:1
    logic run;    // bit 0
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_MODE_LO = 3'd0;
  localparam logic [ADDR_W-1:0] RA_CMP_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_MODE_HI = 3'd2;
  localparam logic [ADDR_W-1:0] RA_CMP_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_CARRIER = 3'd4;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int L = STAGES + 1;

  logic [L-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[L-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[L-2] & ~sh_q[L-1];
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         hit,
  input  logic [W-1:0] cmp,
  output logic [W-1:0] cnt,
  output logic         irq,
  output logic         tog,
  output logic         pwm
);
  logic [W-1:0] cnt_q, cnt_d;
  logic irq_q, irq_d, tog_q, tog_d, pwm_q, pwm_d;

  always_comb begin
    cnt_d = cnt_q;
    tog_d = tog_q;
    irq_d = 1'b0;
    pwm_d = run & (cnt_q < cmp);
    if (!run) begin
      cnt_d = '0;
      tog_d = 1'b0;
    end else if (tick) begin
      if (hit) begin
        cnt_d = '0;
        tog_d = ~tog_q;
        irq_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      tog_q <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
      tog_q <= tog_d;
      pwm_q <= pwm_d;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;
  assign tog = tog_q;
  assign pwm = pwm_q;
endmodule

// File: rtl/tmr_carrier.sv
module tmr_carrier (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic en,
  input  logic third,
  output logic carrier,
  output logic baud
);
  localparam int PH_W = 2;

  logic [PH_W-1:0] ph_q, ph_d, last;
  logic half_q, half_d, baud_q, baud_d;

  always_comb begin
    last = third ? PH_W'(2) : PH_W'(1);
    ph_d = ph_q;
    if (!en)      ph_d = '0;
    else if (ovf) ph_d = (ph_q >= last) ? '0 : ph_q + 1'b1;
    half_d = half_q ^ ovf;
    baud_d = ovf & half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      half_q <= 1'b0;
      baud_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      half_q <= half_d;
      baud_q <= baud_d;
    end
  end

  assign carrier = en & (ph_q == '0);
  assign baud    = baud_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              ce_div4,
  input  logic              ce_div16,
  input  logic [1:0]        ext_cnt,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              pin_lo,
  output logic              pin_hi,
  output logic              carrier_out,
  output logic              baud_tick
);
  localparam int           N       = 2;
  localparam logic [W-1:0] CNT_TOP = '1;

  mode_t        mode_q [N];
  mode_t        mode_d [N];
  logic [W-1:0] cmp_q  [N];
  logic [W-1:0] cmp_d  [N];
  logic         car_en_q, car_en_d, car_3_q, car_3_d;

  // register write decode
  always_comb begin
    for (int i = 0; i < N; i++) begin
      mode_d[i] = mode_q[i];
      cmp_d[i]  = cmp_q[i];
    end
    car_en_d = car_en_q;
    car_3_d  = car_3_q;
    if (wr_en) begin
      case (wr_addr)
        RA_MODE_LO: mode_d[0] = wr_data[MODE_W-1:0];
        RA_CMP_LO:  cmp_d[0]  = wr_data;
        RA_MODE_HI: mode_d[1] = wr_data[MODE_W-1:0];
        RA_CMP_HI:  cmp_d[1]  = wr_data;
        RA_CARRIER: begin
          car_en_d = wr_data[0];
          car_3_d  = wr_data[1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        mode_q[i] <= '0;
        cmp_q[i]  <= '0;
      end
      car_en_q <= 1'b0;
      car_3_q  <= 1'b0;
    end else begin
      for (int i = 0; i < N; i++) begin
        mode_q[i] <= mode_d[i];
        cmp_q[i]  <= cmp_d[i];
      end
      car_en_q <= car_en_d;
      car_3_q  <= car_3_d;
    end
  end

  // count-event source per unit
  logic [N-1:0] src_tick;
  for (genvar g = 0; g < N; g++) begin : g_src
    logic rise, tk;
    tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ext_cnt[g]),
      .rise (rise)
    );
    always_comb begin
      case (mode_q[g].src)
        SRC_CORE:  tk = 1'b1;
        SRC_DIV4:  tk = ce_div4;
        SRC_DIV16: tk = ce_div16;
        default:   tk = rise;
      endcase
    end
    assign src_tick[g] = tk;
  end

  // single or chained operation
  logic [W-1:0] cnt [N];
  logic [N-1:0] run, tick, hit, irq_c, tog, pwm;
  logic         chain, eq_lo, eq_hi, hit_wide;

  always_comb begin
    chain    = mode_q[1].chain;
    eq_lo    = (cnt[0] == cmp_q[0]);
    eq_hi    = (cnt[1] == cmp_q[1]);
    hit_wide = eq_lo & eq_hi;
    run[0]   = mode_q[0].run;
    run[1]   = chain ? mode_q[0].run : mode_q[1].run;
    tick[0]  = src_tick[0];
    tick[1]  = chain ? (src_tick[0] & ((cnt[0] == CNT_TOP) | hit_wide))
                     : src_tick[1];
    hit[0]   = chain ? hit_wide : eq_lo;
    hit[1]   = chain ? hit_wide : eq_hi;
  end

  for (genvar g = 0; g < N; g++) begin : g_unit
    tmr_count_unit #(.W(W)) u_unit (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run[g]),
      .tick (tick[g]),
      .hit  (hit[g]),
      .cmp  (cmp_q[g]),
      .cnt  (cnt[g]),
      .irq  (irq_c[g]),
      .tog  (tog[g]),
      .pwm  (pwm[g])
    );
  end

  tmr_carrier u_carrier (
    .clk    (clk),
    .rst_n  (rst_n),
    .ovf    (irq_c[1]),
    .en     (car_en_q),
    .third  (car_3_q),
    .carrier(carrier_out),
    .baud   (baud_tick)
  );

  assign irq_lo = irq_c[0] & ~chain;
  assign irq_hi = irq_c[1];
  assign pin_lo = mode_q[0].pwm ? pwm[0] : tog[0];
  assign pin_hi = mode_q[1].route ? pwm[0] : (mode_q[1].pwm ? pwm[1] : tog[1]);

  // flat views for the checker
  logic [W-1:0] cnt_lo_v, cnt_hi_v, cmp_lo_v;
  logic         run_lo_v, irqc_lo_v, tog_lo_v, pwm_lo_v;
  assign cnt_lo_v  = cnt[0];
  assign cnt_hi_v  = cnt[1];
  assign cmp_lo_v  = cmp_q[0];
  assign run_lo_v  = run[0];
  assign irqc_lo_v = irq_c[0];
  assign tog_lo_v  = tog[0];
  assign pwm_lo_v  = pwm[0];
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         chain,
  input logic         run_lo,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic [W-1:0] cmp_lo,
  input logic         irqc_lo,
  input logic         tog_lo,
  input logic         pwm_lo,
  input logic         irq_lo,
  input logic         irq_hi,
  input logic         baud_tick
);
  p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lo && !chain && $stable(cmp_lo)) |-> (cnt_lo <= cmp_lo));

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irqc_lo |-> (tog_lo != $past(tog_lo)));

  p_pwm_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_lo == '0 && $stable(cmp_lo)) |=> !pwm_lo);

  p_chain_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && irq_hi) |-> (cnt_lo == '0 && cnt_hi == '0));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_lo && !chain) |=> (cnt_lo == '0 && !irq_lo));

  p_baud_spaced_r9: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);
endmodule

bind tmr_pair tmr_pair_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chain    (chain),
  .run_lo   (run_lo_v),
  .cnt_lo   (cnt_lo_v),
  .cnt_hi   (cnt_hi_v),
  .cmp_lo   (cmp_lo_v),
  .irqc_lo  (irqc_lo_v),
  .tog_lo   (tog_lo_v),
  .pwm_lo   (pwm_lo_v),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi),
  .baud_tick(baud_tick)
);

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ce_div4 = 1'b0;
  logic       ce_div16 = 1'b0;
  logic [1:0] ext_cnt = '0;
  logic irq_lo, irq_hi, pin_lo, pin_hi, carrier_out, baud_tick;

  int vectors = 0;
  int misses  = 0;
  int n_irq_lo = 0;
  bit done = 1'b0;

  tmr_pair u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ce_div4(ce_div4), .ce_div16(ce_div16), .ext_cnt(ext_cnt),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .pin_lo(pin_lo), .pin_hi(pin_hi),
    .carrier_out(carrier_out), .baud_tick(baud_tick)
  );

  always #10 clk = ~clk;

  initial begin
    int pc = 0;
    forever begin
      @(negedge clk);
      pc++;
      ce_div4  = (pc % 4 == 0);
      ce_div16 = (pc % 16 == 0);
    end
  end

  always @(negedge clk) if (irq_lo) n_irq_lo++;

  function automatic logic sig(input int k);
    case (k)
      0: return irq_lo;
      1: return irq_hi;
      2: return baud_tick;
      3: return pin_lo;
      4: return pin_hi;
      default: return carrier_out;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // rising edges from the current point until the signal is seen high
  task automatic wait_evt(input int k, input int limit, output int n);
    bit found = 1'b0;
    n = 0;
    while (!found && n < limit) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (sig(k)) found = 1'b1;
    end
    if (!found) n = -1;
  endtask

  task automatic count_high(input int k, input int cyc, output int h);
    h = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (sig(k)) h++;
    end
  endtask

  task automatic count_chg(input int k, input int cyc, output int c);
    logic prev = sig(k);
    c = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (sig(k) != prev) c++;
      prev = sig(k);
    end
  endtask

  task automatic stop_all();
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h00);
    repeat (3) @(negedge clk);
  endtask

  task automatic pin_pulse(input int hi, input int lo);
    ext_cnt[0] = 1'b1;
    repeat (hi) @(negedge clk);
    ext_cnt[0] = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 irq_lo", irq_lo, 0);
    check("R10 irq_hi", irq_hi, 0);
    check("R10 pin_lo", pin_lo, 0);
    check("R10 pin_hi", pin_hi, 0);
    check("R10 carrier", carrier_out, 0);
    check("R10 baud", baud_tick, 0);
  endtask

  task automatic t_period();
    int n, h;
    wr(3'd1, 8'd9);
    wr(3'd0, 8'h01);            // R11 low mode: run, core clock
    wait_evt(0, 100, n); check("R1 first match latency", n, 10);
    wait_evt(0, 100, n); check("R1 match period", n, 10);
    count_high(0, 100, h); check("R1 one-cycle pulses", h, 10);
    stop_all();
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h01);
    repeat (2) @(negedge clk);
    count_high(0, 20, h); check("R1 compare zero every cycle", h, 20);
    stop_all();
  endtask

  task automatic t_prescale();
    int n;
    wr(3'd1, 8'd2);
    wr(3'd0, 8'h03);            // source 1
    wait_evt(0, 200, n);
    wait_evt(0, 200, n); check("R2 div4 period", n, 12);
    stop_all();
    wr(3'd3, 8'd1);
    wr(3'd2, 8'h05);            // source 2 on the high unit
    wait_evt(1, 200, n);
    wait_evt(1, 200, n); check("R2 div16 period", n, 32);
    stop_all();
  endtask

  task automatic t_pin();
    int s;
    wr(3'd1, 8'd4);
    wr(3'd0, 8'h07);            // source 3
    s = n_irq_lo;
    pin_pulse(10, 4);           // long high counts once
    repeat (3) pin_pulse(3, 3);
    repeat (6) @(negedge clk);
    check("R2 pin four edges no match", n_irq_lo - s, 0);
    pin_pulse(3, 6);
    check("R2 pin fifth edge matches", n_irq_lo - s, 1);
    stop_all();
  endtask

  task automatic t_toggle();
    int c;
    wr(3'd1, 8'd4);
    wr(3'd0, 8'h01);
    repeat (12) @(negedge clk);
    count_chg(3, 100, c); check("R3 toggle transitions", c, 20);
    stop_all();
  endtask

  task automatic t_pwm();
    int h;
    wr(3'd1, 8'd3);
    wr(3'd0, 8'h09);
    repeat (10) @(negedge clk);
    count_high(3, 400, h); check("R4 pwm 3 of 4", h, 300);
    stop_all();
    wr(3'd1, 8'd0);
    wr(3'd0, 8'h09);
    count_high(3, 100, h); check("R4 pwm zero low", h, 0);
    stop_all();
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h09);
    repeat (300) @(negedge clk);
    count_high(3, 512, h); check("R4 pwm full 255 of 256", h, 510);
    stop_all();
  endtask

  task automatic t_chain();
    int n, s;
    wr(3'd2, 8'h14);            // chain, high source div16 ignored
    wr(3'd1, 8'h02);
    wr(3'd3, 8'h01);
    s = n_irq_lo;
    wr(3'd0, 8'h01);
    wait_evt(1, 1000, n); check("R5 chained first match", n, 259);
    wait_evt(1, 1000, n); check("R5 chained period", n, 259);
    check("R5 low irq silent", n_irq_lo - s, 0);
    stop_all();
  endtask

  task automatic t_disable();
    int s, h;
    wr(3'd1, 8'd2);
    wr(3'd0, 8'h01);
    repeat (20) @(negedge clk);
    wr(3'd0, 8'h00);
    @(negedge clk);
    s = n_irq_lo;
    count_high(3, 100, h);
    check("R6 pin low when stopped", h, 0);
    check("R6 no irq when stopped", n_irq_lo - s, 0);
    stop_all();
  endtask

  task automatic t_route();
    int h;
    wr(3'd1, 8'd3);
    wr(3'd0, 8'h09);
    wr(3'd2, 8'h20);
    repeat (10) @(negedge clk);
    count_high(4, 400, h); check("R7 routed pwm on pin_hi", h, 300);
    stop_all();
  endtask

  task automatic t_carrier();
    int h, n;
    wr(3'd3, 8'd4);
    wr(3'd2, 8'h01);
    wr(3'd4, 8'h01);
    repeat (20) @(negedge clk);
    count_high(5, 100, h); check("R8 carrier half duty", h, 50);
    wait_evt(2, 100, n);
    wait_evt(2, 100, n); check("R9 baud interval", n, 10);
    count_high(2, 100, h); check("R9 baud pulses", h, 10);
    wr(3'd4, 8'h03);
    repeat (20) @(negedge clk);
    count_high(5, 150, h); check("R8 carrier third duty", h, 50);
    wr(3'd4, 8'h00);
    count_high(5, 50, h); check("R8 carrier disabled", h, 0);
    stop_all();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period();
    t_prescale();
    t_pin();
    t_toggle();
    t_pwm();
    t_chain();
    t_disable();
    t_route();
    t_carrier();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule